// File: doc/BRIEF.md
# Serial Control Port for an Octal Low-Side Driver

This block is the device-side serial port of an eight-channel low-side switch. A host talks to it over a four-wire serial bus: a serial clock, a data input, an active-low chip select and a data output. The same frame does two jobs at once. It carries the new on/off pattern in, and it returns the level that each channel's output pin showed when the frame began.

All bus pins and the eight sense inputs are sampled by a fast system clock through two-flop synchronizers. Every bus edge is detected from the synchronized samples. When the chip select falls, the eight pin-level sense bits are loaded in parallel into the shift register. While the chip select stays low, a rising serial clock puts the register's top bit on the data output. A falling serial clock shifts the data input into the bottom of the register.

When the chip select rises, the register is copied into the channel control latch. A latch bit of 1 keeps its channel off. The fault logic can force any single latch bit to off at any time through a per-channel clear input. The register passes any number of bits from input to output, so several devices can share one chip select in a daisy chain.

Top module: `lsd_serial_port`

## Requirements
- R1: Asserting `rst_n` low sets `ch_off_o` to all ones and `sdo_o` to 0 at once, without waiting for a clock edge, and clears the shift register. The synchronized chip select resets to high, so `sdo_en_o` is 0.
- R2: On the falling edge of the synchronized chip select, the register loads `sense_i`. Bit n is 1 when channel n's pin is high.
- R3: Each rising serial clock edge while selected puts the register's bit 7 on `sdo_o`. After the load of R2, successive rising edges therefore present sense bits 7, 6, …, 0.
- R4: Each falling serial clock edge while selected shifts the register up by one and takes `sdi_i` into bit 0. The first bit sent ends in bit 7 of the frame's final byte.
- R5: On the rising edge of the chip select pin, the register is copied to `ch_off_o`, and `ch_off_o` changes on the third clock edge after the pin change. It does not change at any other time, except through reset or fault clear.
- R6: A `ch_off_o` bit of 0 means the channel is on and 1 means it is off. After a frame, each `ch_off_o` bit equals the bit sent for that channel.
- R7: `sdo_en_o` is 1 exactly while the synchronized chip select is low. The output buffer is released otherwise.
- R8: While the chip select is high, serial clock and data activity change neither `sdo_o` nor the shift register.
- R9: In a frame longer than eight bits, the data output returns the sense byte followed by the bits sent eight clocks earlier. The control latch takes the last eight bits sent.
- R10: A 1 on `fault_off_i[n]` forces `ch_off_o[n]` to 1 on the next clock edge. The forced bit stays 1 after the clear is released, and the clear wins over a commit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Active-low reset, asserts asynchronously |
| sclk_i | input | 1 | Serial clock pin |
| sdi_i | input | 1 | Serial data in pin |
| cs_n_i | input | 1 | Active-low chip select pin |
| sense_i | input | 8 | Per-channel output-pin level, 1 = pin high |
| fault_off_i | input | 8 | Per-channel force-off request from fault logic |
| sdo_o | output | 1 | Serial data out value |
| sdo_en_o | output | 1 | Drive enable for the serial data out buffer |
| ch_off_o | output | 8 | Channel control latch, 1 = channel off |

## Verification
Each pin change reaches the state three system-clock edges later: two edges through the synchronizer and one for the edge-detected update. The bench therefore holds every serial pin level for four clocks and samples on the falling clock edge that follows. The commit latency is checked exactly, with `ch_off_o` shown unchanged after the second edge and updated after the third. The fault clear bypasses the synchronizers, so it is checked one edge after it is driven, and the reset value is checked before any edge occurs.

// File: rtl/lsd_serial_pkg.sv
// Shared types for the low-side driver serial port.
// Assumes one event of each kind per system clock at most.
package lsd_serial_pkg;

    // Per-cycle bus events decoded from synchronized pin samples.
    typedef struct packed {
        logic load;      // chip select fell: capture sense bits
        logic shift_out; // serial clock rose while selected
        logic shift_in;  // serial clock fell while selected
        logic commit;    // chip select rose: update control latch
    } bus_evt_t;

endpackage

// File: rtl/pin_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous pins.
// Assumes the bits are independent or stable across a sample window.
module pin_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture raw pin levels.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= d_i;
            end
        end else begin : g_next
            // Pass the sample down the chain.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/bus_edge_decode.sv
// Turns synchronized chip select and serial clock levels into
// single-cycle bus events. Clock edges only count while the chip
// select is low both now and in the previous sample.
module bus_edge_decode
    import lsd_serial_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sclk_s_i,
    input  logic     cs_n_s_i,
    output bus_evt_t evt_o
);

    logic cs_n_prev_q;
    logic sclk_prev_q;
    logic sel_steady;

    // Remember the last synchronized levels for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_prev_q <= 1'b1;
            sclk_prev_q <= 1'b0;
        end else begin
            cs_n_prev_q <= cs_n_s_i;
            sclk_prev_q <= sclk_s_i;
        end
    end

    assign sel_steady = !cs_n_s_i && !cs_n_prev_q;

    // Decode the four event kinds.
    always_comb begin
        evt_o.load      = cs_n_prev_q && !cs_n_s_i;
        evt_o.commit    = !cs_n_prev_q && cs_n_s_i;
        evt_o.shift_out = sel_steady && sclk_s_i && !sclk_prev_q;
        evt_o.shift_in  = sel_steady && !sclk_s_i && sclk_prev_q;
    end

    // R2
    evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_o.load, evt_o.commit, evt_o.shift_out, evt_o.shift_in}));

    // R8
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s_i |-> !(evt_o.shift_out || evt_o.shift_in));

endmodule

// File: rtl/diag_shifter.sv
// Shift register with parallel sense load, serial in on one clock
// edge and serial out on the other. MSB leaves first.
module diag_shifter
    import lsd_serial_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  bus_evt_t     evt_i,
    input  logic [W-1:0] par_i,
    input  logic         ser_i,
    output logic [W-1:0] reg_o,
    output logic         ser_o
);

    logic [W-1:0] sreg_q;
    logic         so_q;

    // Parallel load at frame start, shift in on falling serial clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               sreg_q <= '0;
        else if (evt_i.load)      sreg_q <= par_i;
        else if (evt_i.shift_in)  sreg_q <= {sreg_q[W-2:0], ser_i};
    end

    // Present the top bit on rising serial clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               so_q <= 1'b0;
        else if (evt_i.shift_out) so_q <= sreg_q[W-1];
    end

    assign reg_o = sreg_q;
    assign ser_o = so_q;

    // R2
    load_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.load |=> sreg_q == $past(par_i));

    // R8
    sreg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_i.load || evt_i.shift_in) |=> $stable(sreg_q));

    // R3
    so_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_i.shift_out |=> $stable(so_q));

endmodule

// File: rtl/chan_latch.sv
// Channel control latch, 1 = channel off. Loads on commit; each bit
// can be forced off by its clear input, which wins over a commit.
module chan_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit_i,
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] off_o
);

    logic [W-1:0] off_q;

    // Commit new pattern, then apply per-bit force-off.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) off_q <= '1;
        else        off_q <= (commit_i ? data_i : off_q) | clr_i;
    end

    assign off_o = off_q;

    // R10
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((off_q & $past(clr_i)) == $past(clr_i)));

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_i && clr_i == '0) |=> $stable(off_q));

    // R6
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && clr_i == '0) |=> off_q == $past(data_i));

endmodule

// File: rtl/lsd_serial_port.sv
// Top of the serial port: synchronizes the pins and sense bits,
// decodes bus events, runs the diagnostic shifter and holds the
// channel latch. Assumes clk is at least four times the serial clock.
module lsd_serial_port
    import lsd_serial_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int SYNC_STG = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk_i,
    input  logic           sdi_i,
    input  logic           cs_n_i,
    input  logic [NCH-1:0] sense_i,
    input  logic [NCH-1:0] fault_off_i,
    output logic           sdo_o,
    output logic           sdo_en_o,
    output logic [NCH-1:0] ch_off_o
);

    localparam int SW = NCH + 3;
    localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b0, 1'b1, {NCH{1'b0}}};

    logic [SW-1:0]  sync_q;
    logic           sclk_s, sdi_s, cs_n_s;
    logic [NCH-1:0] sense_s;
    logic [NCH-1:0] sreg;
    bus_evt_t       evt;

    pin_sync #(.W(SW), .STAGES(SYNC_STG), .RST_VAL(SYNC_RST)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sclk_i, sdi_i, cs_n_i, sense_i}),
        .q_o   (sync_q)
    );

    assign {sclk_s, sdi_s, cs_n_s, sense_s} = sync_q;

    bus_edge_decode i_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s_i (sclk_s),
        .cs_n_s_i (cs_n_s),
        .evt_o    (evt)
    );

    diag_shifter #(.W(NCH)) i_shf (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt),
        .par_i (sense_s),
        .ser_i (sdi_s),
        .reg_o (sreg),
        .ser_o (sdo_o)
    );

    chan_latch #(.W(NCH)) i_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (evt.commit),
        .data_i   (sreg),
        .clr_i    (fault_off_i),
        .off_o    (ch_off_o)
    );

    assign sdo_en_o = !cs_n_s;

    // R7
    so_en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt.load |-> sdo_en_o);

endmodule

// File: tb/test_lsd_serial_port.sv
module test_lsd_serial_port;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 4;
    localparam int NV = 4;
    // {sense, sent byte, expected returned byte, expected ch_off}
    localparam logic [31:0] VEC [NV] = '{
        {8'hA5, 8'h3C, 8'hA5, 8'h3C},
        {8'h00, 8'hFF, 8'h00, 8'hFF},
        {8'hFF, 8'h00, 8'hFF, 8'h00},
        {8'h5A, 8'h81, 8'h5A, 8'h81}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1;
    logic [7:0] sense = 8'h00, fault = 8'h00;
    logic sdo, sdo_en;
    logic [7:0] ch_off;
    int checks = 0, fails = 0;
    logic [15:0] rx16;
    logic [7:0] rx8;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsd_serial_port i_lsd_serial_port (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .cs_n_i(cs_n),
        .sense_i(sense), .fault_off_i(fault),
        .sdo_o(sdo), .sdo_en_o(sdo_en), .ch_off_o(ch_off)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wait_n(HOLD);
    endtask

    task automatic desel();
        cs_n = 1'b1;
        wait_n(HOLD);
    endtask

    // Send nb bits MSB first, collect returned bits.
    task automatic bits(input int nb, input logic [15:0] tx, output logic [15:0] rx);
        rx = '0;
        for (int i = nb - 1; i >= 0; i--) begin
            sdi = tx[i];
            wait_n(HOLD);
            sclk = 1'b1;
            wait_n(HOLD);
            rx[i] = sdo;
            sclk = 1'b0;
            wait_n(HOLD);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        wait_n(1);
        // R1: reset state
        chk("R1 ch_off", {8'h0, ch_off}, 16'h00FF);
        chk("R1 sdo", {15'h0, sdo}, 16'h0);
        chk("R7 sdo_en in reset", {15'h0, sdo_en}, 16'h0);
        wait_n(2);
        rst_n = 1'b1;
        wait_n(HOLD);

        // R2 R3 R4 R6: vector table
        for (int v = 0; v < NV; v++) begin
            sense = VEC[v][31:24];
            wait_n(HOLD);
            sel();
            chk("R7 sdo_en selected", {15'h0, sdo_en}, 16'h1);
            bits(8, {8'h0, VEC[v][23:16]}, rx16);
            chk("R2 R3 returned sense", rx16, {8'h0, VEC[v][15:8]});
            desel();
            chk("R4 R6 ch_off", {8'h0, ch_off}, {8'h0, VEC[v][7:0]});
            chk("R7 sdo_en released", {15'h0, sdo_en}, 16'h0);
        end

        // R8: serial clock toggles while deselected leave sdo alone
        for (int k = 0; k < 3; k++) begin
            sdi = 1'b1;
            sclk = 1'b1;
            wait_n(HOLD);
            sclk = 1'b0;
            wait_n(HOLD);
        end
        chk("R8 sdo held", {15'h0, sdo}, 16'h0);
        chk("R8 ch_off held", {8'h0, ch_off}, 16'h0081);

        // R5: no change mid-frame, exact commit latency
        sense = 8'h0F;
        wait_n(HOLD);
        sel();
        bits(4, 16'h0000, rx16);
        chk("R5 mid-frame", {8'h0, ch_off}, 16'h0081);
        bits(4, 16'h0006, rx16);
        cs_n = 1'b1;
        wait_n(2);
        chk("R5 before third edge", {8'h0, ch_off}, 16'h0081);
        wait_n(1);
        chk("R5 after third edge", {8'h0, ch_off}, 16'h0006);
        wait_n(HOLD);

        // R9: sixteen-bit daisy-chain frame
        sense = 8'hC3;
        wait_n(HOLD);
        sel();
        bits(16, 16'h6E17, rx16);
        chk("R9 chained return", rx16, 16'hC36E);
        desel();
        chk("R9 last byte latched", {8'h0, ch_off}, 16'h0017);

        // R10: fault clear forces a bit off next edge and sticks
        fault = 8'h08;
        wait_n(1);
        chk("R10 forced off", {8'h0, ch_off}, 16'h001F);
        fault = 8'h00;
        wait_n(2);
        chk("R10 stays off", {8'h0, ch_off}, 16'h001F);

        // R10: clear wins over a same-cycle commit
        sel();
        bits(8, 16'h0000, rx8);
        fault = 8'h01;
        desel();
        fault = 8'h00;
        wait_n(1);
        chk("R10 priority over commit", {8'h0, ch_off}, 16'h0001);

        // R1: asynchronous reset mid-cycle
        #2 rst_n = 1'b0;
        #1;
        chk("R1 async ch_off", {8'h0, ch_off}, 16'h00FF);
        chk("R1 async sdo", {15'h0, sdo}, 16'h0);
        wait_n(2);
        rst_n = 1'b1;
        wait_n(2);
        summary();
    end

endmodule